// File: doc/BRIEF.md
# Byte-Addressed Instruction Fetch Unit

This block feeds a small 16-bit processor one instruction every clock. A program counter register holds the current fetch address. A separate adder produces the counter value plus two and feeds it back into the register, so the register itself only stores its input. The counter is cleared asynchronously while the active-low reset is held.

The counter addresses a read-only store that is organised as bytes. Each instruction occupies two consecutive byte entries, and the lower address holds the least significant byte. The store is always read and never written, and its contents come from a parameter at elaboration. The default image is computed from a simple formula, so no external file is involved. Both the current counter value and the instruction assembled from the two bytes it points to appear at the outputs within the same cycle.

The block has no state machine beyond the counter register. The counter moves through two phases. While `rst_n` is low it is held at zero. Once `rst_n` is high it steps by two on every rising edge.

Top module: `fetch_unit`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0x0000, and it clears as soon as `rst_n` falls, without waiting for a clock edge.
- R2: The first rising clock edge after `rst_n` goes high moves `pc_o` from 0x0000 to 0x0002.
- R3: On every rising edge with `rst_n` high, `pc_o` becomes its previous value plus 2.
- R4: `pc_o` wraps from 0xFFFE to 0x0000 on the next rising edge.
- R5: `instr_o` equals {byte[pc_o+1], byte[pc_o]}, with the byte at the lower address in bits 7:0. It is valid combinationally in the same cycle as `pc_o`.
- R6: A byte address at or above `DEPTH` reads as 0x00, so `instr_o` is 0x0000 when `pc_o` is at or beyond `DEPTH`.
- R7: With default parameters (`DEPTH` = 64), byte address i holds (37*i + 11) mod 256.
- R8: `pc_o` bit 0 is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the program counter |
| pc_o | output | 16 | Current fetch address |
| instr_o | output | 16 | Instruction at `pc_o`, low byte taken from the lower address |

## Verification
The counter is registered. A change on `pc_o` is due one rising edge after the stimulus, and the clearing done by reset is due immediately after `rst_n` falls. `instr_o` is combinational from `pc_o`, so it is due in the same cycle as the counter value it belongs to. The bench changes inputs on falling edges and samples both outputs on the following falling edge, which is exactly one register stage later. The reset check samples a short delay after `rst_n` falls, before any rising edge arrives.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    localparam int unsigned PC_W      = 16;
    localparam int unsigned MAX_BYTES = 256;
    localparam int unsigned PC_STEP   = 2;

    typedef logic [PC_W-1:0] addr_t;
    typedef logic [7:0]      byte_t;

    // Default store image: entry i holds (37*i + 11) mod 256.
    function automatic logic [8*MAX_BYTES-1:0] seed_image();
        logic [8*MAX_BYTES-1:0] img;
        img = '0;
        for (int i = 0; i < int'(MAX_BYTES); i++) begin
            img[8*i +: 8] = 8'((37 * i + 11) % 256);
        end
        return img;
    endfunction

endpackage

// File: rtl/fetch_pc_adder.sv
module fetch_pc_adder
    import fetch_pkg::*;
(
    input  addr_t pc_i,
    output addr_t pc_next_o
);

    // Modular add: 0xFFFE rolls to 0x0000.
    assign pc_next_o = pc_i + addr_t'(PC_STEP);

endmodule

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg
    import fetch_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  addr_t d_i,
    output addr_t q_o
);

    addr_t pc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= d_i;
        end
    end

    assign q_o = pc_q;

    // R1: held at zero while reset is low
    always @(posedge clk) begin
        if (!rst_n) begin
            a_reset_zero_r1: assert (pc_q == '0)
                else $error("pc not zero under reset");
        end
    end

    // R3: steps by two away from the wrap point
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_q != 16'hFFFE) |=> (pc_q == $past(pc_q) + 16'd2));

    // R4: wraps to zero
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_q == 16'hFFFE) |=> (pc_q == 16'h0000));

    // R8: never odd
    p_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_q[0] == 1'b0));

endmodule

// File: rtl/fetch_byte_rom.sv
module fetch_byte_rom
    import fetch_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter logic [8*MAX_BYTES-1:0] IMAGE = seed_image()
) (
    input  addr_t addr_i,
    output logic [15:0] word_o
);

    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    initial begin
        if (DEPTH > MAX_BYTES || DEPTH < 2 || (DEPTH % 2) != 0) begin
            $error("DEPTH must be even and within 2..MAX_BYTES");
        end
    end

    byte_t rom_q [DEPTH];

    for (genvar g = 0; g < int'(DEPTH); g++) begin : g_entry
        assign rom_q[g] = IMAGE[8*g +: 8];
    end

    // The address is always even, so the partner byte sits at addr | 1.
    addr_t lo_addr;
    addr_t hi_addr;
    byte_t lo_byte;
    byte_t hi_byte;

    assign lo_addr = addr_i;
    assign hi_addr = {addr_i[PC_W-1:1], 1'b1};

    always_comb begin
        lo_byte = '0;
        hi_byte = '0;
        if (32'(lo_addr) < DEPTH) lo_byte = rom_q[lo_addr[IDX_W-1:0]];
        if (32'(hi_addr) < DEPTH) hi_byte = rom_q[hi_addr[IDX_W-1:0]];
    end

    assign word_o = {hi_byte, lo_byte};

    // R6: outside the store the word is zero
    always_comb begin
        if (32'(addr_i) >= DEPTH) begin
            a_beyond_zero_r6: assert (word_o == 16'h0000)
                else $error("nonzero read beyond store");
        end
    end

endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
    import fetch_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter logic [8*MAX_BYTES-1:0] IMAGE = seed_image()
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] pc_o,
    output logic [15:0] instr_o
);

    addr_t pc_cur;
    addr_t pc_nxt;

    fetch_pc_adder u_adder (
        .pc_i      (pc_cur),
        .pc_next_o (pc_nxt)
    );

    fetch_pc_reg u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pc_nxt),
        .q_o   (pc_cur)
    );

    fetch_byte_rom #(
        .DEPTH (DEPTH),
        .IMAGE (IMAGE)
    ) u_rom (
        .addr_i (pc_cur),
        .word_o (instr_o)
    );

    assign pc_o = pc_cur;

    // R2: first edge after reset release lands on address 2
    p_first_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |=> (pc_o == 16'h0002));

endmodule

// File: tb/fetch_unit_test.sv
`timescale 1ns/1ps
module fetch_unit_test;

    localparam int DEPTH = 64;
    localparam int NSTEP = 12;
    localparam logic [15:0] EXP_PC [NSTEP] = '{
        16'd2, 16'd4, 16'd6, 16'd8, 16'd10, 16'd12,
        16'd14, 16'd16, 16'd18, 16'd20, 16'd22, 16'd24
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] pc_o;
    logic [15:0] instr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    fetch_unit uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .pc_o    (pc_o),
        .instr_o (instr_o)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] exp_byte(input int a);
        if (a < DEPTH) return 8'((37 * a + 11) % 256);
        return 8'h00;
    endfunction

    function automatic logic [15:0] exp_word(input logic [15:0] pc);
        return {exp_byte(int'(pc) + 1), exp_byte(int'(pc))};
    endfunction

    task automatic check16(input string req, input logic [15:0] act,
                           input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%04h expected=%04h", req, act, exp);
        end
    endtask

    initial begin
        // Reset state (R1) and word at address 0 (R5, R7)
        @(negedge clk);
        @(negedge clk);
        check16("R1 reset pc", pc_o, 16'h0000);
        check16("R5 R7 word at 0", instr_o, exp_word(16'h0000));

        // Release; the first edge gives 2 (R2), then table walk (R3, R5, R7)
        rst_n = 1'b1;
        for (int i = 0; i < NSTEP; i++) begin
            @(negedge clk);
            check16(i == 0 ? "R2 first step" : "R3 step", pc_o, EXP_PC[i]);
            check16("R5 R7 word", instr_o, exp_word(EXP_PC[i]));
            check16("R8 even", {15'd0, pc_o[0]}, 16'h0000);
        end

        // Last word inside the store, then beyond it (R6)
        while (pc_o != 16'd62) @(negedge clk);
        check16("R7 last word", instr_o, exp_word(16'd62));
        @(negedge clk);
        check16("R3 to 64", pc_o, 16'd64);
        check16("R6 beyond store", instr_o, 16'h0000);
        @(negedge clk);
        check16("R6 beyond store 66", instr_o, 16'h0000);

        // Wrap (R4)
        while (pc_o != 16'hFFFE) @(negedge clk);
        check16("R6 top word", instr_o, 16'h0000);
        @(negedge clk);
        check16("R4 wrap", pc_o, 16'h0000);
        check16("R5 word after wrap", instr_o, exp_word(16'h0000));
        @(negedge clk);
        check16("R3 after wrap", pc_o, 16'h0002);

        // Mid-run reset clears at once (R1) and restarts cleanly (R2)
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        #2;
        check16("R1 async clear", pc_o, 16'h0000);
        @(negedge clk);
        check16("R1 held", pc_o, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check16("R2 restart", pc_o, 16'h0002);
        check16("R5 word at 2", instr_o, exp_word(16'h0002));

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule